// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Receiver

This block takes the raw clock and data wires of a PS/2 keyboard and turns them into key events. Both wires are first resynchronised to the system clock and cleaned by a stability filter. Bits are then taken on each falling edge of the cleaned keyboard clock. A complete frame is eleven bits, checked for a low start bit, a high stop bit and odd parity. A good frame yields one byte and a bad frame yields a one-cycle error pulse.

Bytes go to a small prefix tracker. The release prefix (0xF0) and the extended prefix (0xE0) are absorbed and remembered. The next ordinary byte is reported as one event: the scan code, a break flag and an extended flag. A key held down sends its make code again and again, and each repeat is reported as a new event. A frame that stalls partway is dropped once the keyboard clock has been quiet longer than a timeout, so the next frame starts cleanly.

Top module: `ps2kb_receiver`

## Requirements
- R1: While reset is held, and in the first cycles after it, `key_valid` and `frame_err` are 0.
- R2: A valid frame carries, in order, a 0 start bit, eight data bits with bit 0 first, an odd-parity bit and a 1 stop bit. For an ordinary byte (not 0xF0 or 0xE0) it produces exactly one single-cycle `key_valid` pulse with `key_code` equal to the byte, `key_break`=0 and `key_ext`=0.
- R3: The byte 0xF0 produces no event. The next ordinary byte is reported with `key_break`=1.
- R4: The byte 0xE0 produces no event. The next ordinary byte is reported with `key_ext`=1. The sequence E0, F0, code is reported as one event with both flags set.
- R5: Prefix flags accumulate in any order and number (for example F0 E0 code, F0 F0 code, E0 E0 code) until an ordinary byte ends the event. They are then cleared.
- R6: Repeating the same make frame produces one new event per frame.
- R7: A frame with a wrong start bit, a wrong stop bit or even parity produces one single-cycle `frame_err` pulse and no event.
- R8: A framing or parity error clears any pending prefix, so F0, bad frame, code is reported with `key_break`=0.
- R9: If no falling keyboard-clock edge arrives for `TIMEOUT_CYC` system cycles partway through a frame, the partial frame is dropped without an error pulse. A following full frame is decoded normally.
- R10: A pulse on the keyboard clock line shorter than `FILT_LEN` system cycles is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kb_clk_in | input | 1 | Raw keyboard clock line, idle high |
| kb_dat_in | input | 1 | Raw keyboard data line, idle high |
| key_valid | output | 1 | One-cycle event strobe |
| key_code | output | 8 | Scan code of the event |
| key_break | output | 1 | 1 for a key release |
| key_ext | output | 1 | 1 for an extended key |
| frame_err | output | 1 | One-cycle pulse on a rejected frame |

## Verification
The assertions assume the keyboard clock stays low and high for many more system cycles than the filter length. Under that condition every event and error follows a real falling edge, with a fixed pipeline delay. They also assume that an error and an event never coincide. The stimulus keeps each half bit period at ten system cycles against a filter of four. It changes data only while the keyboard clock is high, and it keeps bit spacing well under the timeout. Glitches and stalls are injected only on purpose, in the R9 and R10 cases.

// File: rtl/ps2kb_pkg.sv
// Shared constants and types for the PS/2 keyboard receiver.
package ps2kb_pkg;
    localparam logic [7:0] BRK_PREFIX  = 8'hF0;
    localparam logic [7:0] EXT_PREFIX  = 8'hE0;
    localparam int         FRAME_BITS  = 11;

    typedef struct packed {
        logic [7:0] code;
        logic       brk;
        logic       ext;
    } key_evt_t;
endpackage

// File: rtl/ps2kb_line_filter.sv
// Resynchronises one asynchronous PS/2 line and filters glitches out of it.
// The output changes only after FILT_LEN consecutive equal samples.
// Assumes the line idles high; the output resets to 1.
module ps2kb_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;
    logic                   out_q;

    // Synchroniser chain that brings the line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
    end

    // Sample history used for the stability decision.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '1;
        else        hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
    end

    // Output follows the history only when every sample agrees.
    always_ff @(posedge clk) begin
        if (!rst_n)          out_q <= 1'b1;
        else if (&hist_q)    out_q <= 1'b1;
        else if (~|hist_q)   out_q <= 1'b0;
    end

    assign line_out = out_q;
endmodule

// File: rtl/ps2kb_frame_rx.sv
// Collects eleven-bit PS/2 frames on falling edges of the filtered clock.
// It checks start, stop and odd parity, and drops a stalled partial frame.
// Assumes clean, synchronous inputs from ps2kb_line_filter.
module ps2kb_frame_rx
    import ps2kb_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kb_clk_f,
    input  logic       kb_dat_f,
    output logic       clk_fall,
    output logic       byte_stb,
    output logic [7:0] byte_data,
    output logic       frame_err
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [TO_W-1:0]  TO_LAST  = TO_W'(TIMEOUT_CYC - 1);

    logic                  clk_prev_q;
    logic [CNT_W-1:0]      bit_cnt_q;
    logic [TO_W-1:0]       idle_cnt_q;
    logic [FRAME_BITS-1:0] sr_q;
    logic [FRAME_BITS-1:0] sr_nxt;
    logic                  frame_ok;
    logic                  stb_q;
    logic                  err_q;
    logic [7:0]            data_q;

    assign clk_fall = clk_prev_q & ~kb_clk_f;
    assign sr_nxt   = {kb_dat_f, sr_q[FRAME_BITS-1:1]};
    assign frame_ok = (sr_nxt[0] == 1'b0) && (sr_nxt[FRAME_BITS-1] == 1'b1)
                      && (^sr_nxt[9:1] == 1'b1);

    // Previous filtered clock level, used for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev_q <= 1'b1;
        else        clk_prev_q <= kb_clk_f;
    end

    // Bit counter, shift register and inter-edge timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            idle_cnt_q <= '0;
            sr_q       <= '1;
        end else if (clk_fall) begin
            sr_q       <= sr_nxt;
            idle_cnt_q <= '0;
            bit_cnt_q  <= (bit_cnt_q == LAST_BIT) ? '0 : bit_cnt_q + 1'b1;
        end else if (bit_cnt_q != '0) begin
            if (idle_cnt_q == TO_LAST) begin
                bit_cnt_q  <= '0;
                idle_cnt_q <= '0;
            end else begin
                idle_cnt_q <= idle_cnt_q + 1'b1;
            end
        end
    end

    // Frame verdict, registered once on the last bit edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q  <= 1'b0;
            err_q  <= 1'b0;
            data_q <= '0;
        end else begin
            stb_q <= clk_fall && (bit_cnt_q == LAST_BIT) && frame_ok;
            err_q <= clk_fall && (bit_cnt_q == LAST_BIT) && !frame_ok;
            if (clk_fall && (bit_cnt_q == LAST_BIT)) data_q <= sr_nxt[8:1];
        end
    end

    assign byte_stb  = stb_q;
    assign frame_err = err_q;
    assign byte_data = data_q;
endmodule

// File: rtl/ps2kb_prefix_tracker.sv
// Absorbs release and extended prefix bytes and emits one event for each
// ordinary byte, with the flags gathered since the last event.
// Assumes byte_stb and frame_err never coincide.
module ps2kb_prefix_tracker
    import ps2kb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     byte_stb,
    input  logic [7:0] byte_data,
    input  logic     frame_err,
    output logic     evt_valid,
    output key_evt_t evt
);
    logic     brk_pend_q;
    logic     ext_pend_q;
    logic     valid_q;
    key_evt_t evt_q;
    logic     is_brk;
    logic     is_ext;

    assign is_brk = (byte_data == BRK_PREFIX);
    assign is_ext = (byte_data == EXT_PREFIX);

    // Pending prefix flags: set by prefixes, cleared by events and errors.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_err) begin
            brk_pend_q <= 1'b0;
            ext_pend_q <= 1'b0;
        end else if (byte_stb) begin
            if (is_brk)      brk_pend_q <= 1'b1;
            else if (is_ext) ext_pend_q <= 1'b1;
            else begin
                brk_pend_q <= 1'b0;
                ext_pend_q <= 1'b0;
            end
        end
    end

    // Event register: strobe for one cycle, fields held until the next event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            evt_q   <= '0;
        end else begin
            valid_q <= byte_stb && !is_brk && !is_ext;
            if (byte_stb && !is_brk && !is_ext)
                evt_q <= '{code: byte_data, brk: brk_pend_q, ext: ext_pend_q};
        end
    end

    assign evt_valid = valid_q;
    assign evt       = evt_q;
endmodule

// File: rtl/ps2kb_receiver.sv
// Top of the PS/2 keyboard receiver: line filters, frame receiver, prefix
// tracker. Assumes a system clock much faster than the keyboard clock.
module ps2kb_receiver
    import ps2kb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 8,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kb_clk_in,
    input  logic       kb_dat_in,
    output logic       key_valid,
    output logic [7:0] key_code,
    output logic       key_break,
    output logic       key_ext,
    output logic       frame_err
);
    logic       kb_clk_f;
    logic       kb_dat_f;
    logic       clk_fall;
    logic       byte_stb;
    logic [7:0] byte_data;
    key_evt_t   evt;

    ps2kb_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_clk_filt (
        .clk(clk), .rst_n(rst_n), .line_in(kb_clk_in), .line_out(kb_clk_f)
    );

    ps2kb_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_dat_filt (
        .clk(clk), .rst_n(rst_n), .line_in(kb_dat_in), .line_out(kb_dat_f)
    );

    ps2kb_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
        .clk(clk), .rst_n(rst_n), .kb_clk_f(kb_clk_f), .kb_dat_f(kb_dat_f),
        .clk_fall(clk_fall), .byte_stb(byte_stb), .byte_data(byte_data),
        .frame_err(frame_err)
    );

    ps2kb_prefix_tracker u_prefix (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_data(byte_data),
        .frame_err(frame_err), .evt_valid(key_valid), .evt(evt)
    );

    assign key_code  = evt.code;
    assign key_break = evt.brk;
    assign key_ext   = evt.ext;
endmodule

// File: rtl/ps2kb_checker.sv
// Temporal checks for ps2kb_receiver, attached by bind.
module ps2kb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_fall,
    input logic       key_valid,
    input logic [7:0] key_code,
    input logic       frame_err
);
    // R2: the event strobe lasts a single cycle
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid);

    // R2: an event follows a keyboard clock fall by two cycles
    a_r2_event_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> $past(clk_fall, 2));

    // R3 and R4: prefix bytes are never reported as codes
    a_r3_no_prefix_event: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> (key_code != 8'hF0 && key_code != 8'hE0));

    // R7: error pulse is single-cycle and follows an edge
    a_r7_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    a_r7_err_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(clk_fall));

    // R7: a rejected frame never also produces an event
    a_r7_err_excl_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_err && key_valid));
endmodule

bind ps2kb_receiver ps2kb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .clk_fall(clk_fall), .key_valid(key_valid),
    .key_code(key_code), .frame_err(frame_err)
);

// File: tb/ps2kb_receiver_tb.sv
module ps2kb_receiver_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FILT       = 4;
    localparam int TMO        = 100;
    localparam int HP         = 10;
    localparam int GAP        = 30;
    localparam int WDOG       = 195000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kb_clk = 1'b1;
    logic kb_dat = 1'b1;
    logic       key_valid;
    logic [7:0] key_code;
    logic       key_break;
    logic       key_ext;
    logic       frame_err;

    int n_chk = 0, n_fail = 0;
    int ev_cnt = 0, er_cnt = 0, ev0 = 0, er0 = 0;
    logic [7:0] last_code = '0;
    logic last_brk = 1'b0, last_ext = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ps2kb_receiver #(.SYNC_STAGES(2), .FILT_LEN(FILT), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .kb_clk_in(kb_clk), .kb_dat_in(kb_dat),
        .key_valid(key_valid), .key_code(key_code), .key_break(key_break),
        .key_ext(key_ext), .frame_err(frame_err)
    );

    // Monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (rst_n && key_valid) begin
            ev_cnt++;
            last_code = key_code; last_brk = key_break; last_ext = key_ext;
        end
        if (rst_n && frame_err) er_cnt++;
    end

    function automatic logic [10:0] mk(input logic [7:0] d);
        return {1'b1, ~^d, d, 1'b0};
    endfunction

    task automatic send_bits(input logic [10:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); kb_dat = b[i];
            repeat (HP) @(negedge clk); kb_clk = 1'b0;
            repeat (HP) @(negedge clk); kb_clk = 1'b1;
        end
        kb_dat = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic snap();
        ev0 = ev_cnt; er0 = er_cnt;
    endtask

    task automatic exp_evt(input logic [7:0] c, input logic b, input logic e, input string tag);
        n_chk++;
        if (ev_cnt - ev0 != 1 || er_cnt != er0 || last_code != c || last_brk != b || last_ext != e) begin
            n_fail++;
            $display("FAIL %s: got ev=%0d err=%0d code=%02h brk=%0d ext=%0d, expected ev=1 err=0 code=%02h brk=%0d ext=%0d",
                     tag, ev_cnt - ev0, er_cnt - er0, last_code, last_brk, last_ext, c, b, e);
        end
    endtask

    task automatic exp_err(input int n_err, input string tag);
        n_chk++;
        if (ev_cnt != ev0 || er_cnt - er0 != n_err) begin
            n_fail++;
            $display("FAIL %s: got ev=%0d err=%0d, expected ev=0 err=%0d",
                     tag, ev_cnt - ev0, er_cnt - er0, n_err);
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (5) @(negedge clk);
        n_chk++;
        if (key_valid !== 1'b0 || frame_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got valid=%b err=%b, expected 0 0", key_valid, frame_err);
        end
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        n_chk++;
        if (key_valid !== 1'b0 || frame_err !== 1'b0 || ev_cnt != 0 || er_cnt != 0) begin
            n_fail++;
            $display("FAIL R1: got ev=%0d err=%0d after reset, expected 0 0", ev_cnt, er_cnt);
        end

        // R2: every ordinary code as a make event
        for (int c = 0; c < 256; c++) begin
            if (c != 8'hF0 && c != 8'hE0) begin
                snap(); send_bits(mk(8'(c)), 11);
                exp_evt(8'(c), 1'b0, 1'b0, "R2 make");
            end
        end

        // R3: break events
        for (int c = 1; c < 256; c += 4) begin
            if (c != 8'hF0 && c != 8'hE0) begin
                snap(); send_bits(mk(8'hF0), 11); send_bits(mk(8'(c)), 11);
                exp_evt(8'(c), 1'b1, 1'b0, "R3 break");
            end
        end

        // R4: extended make and extended break
        for (int c = 3; c < 256; c += 8) begin
            snap(); send_bits(mk(8'hE0), 11); send_bits(mk(8'(c)), 11);
            exp_evt(8'(c), 1'b0, 1'b1, "R4 ext make");
        end
        for (int c = 5; c < 256; c += 8) begin
            snap(); send_bits(mk(8'hE0), 11); send_bits(mk(8'hF0), 11); send_bits(mk(8'(c)), 11);
            exp_evt(8'(c), 1'b1, 1'b1, "R4 ext break");
        end

        // R5: accumulation of prefixes in other orders
        snap(); send_bits(mk(8'hF0), 11); send_bits(mk(8'hE0), 11); send_bits(mk(8'h75), 11);
        exp_evt(8'h75, 1'b1, 1'b1, "R5 F0 E0");
        snap(); send_bits(mk(8'hF0), 11); send_bits(mk(8'hF0), 11); send_bits(mk(8'h1C), 11);
        exp_evt(8'h1C, 1'b1, 1'b0, "R5 F0 F0");
        snap(); send_bits(mk(8'hE0), 11); send_bits(mk(8'hE0), 11); send_bits(mk(8'h6B), 11);
        exp_evt(8'h6B, 1'b0, 1'b1, "R5 E0 E0");
        snap(); send_bits(mk(8'h29), 11);
        exp_evt(8'h29, 1'b0, 1'b0, "R5 flags cleared");

        // R6: held key repeats
        for (int k = 0; k < 4; k++) begin
            snap(); send_bits(mk(8'h1D), 11);
            exp_evt(8'h1D, 1'b0, 1'b0, "R6 repeat");
        end

        // R7: bad parity, bad start, bad stop
        snap(); send_bits(mk(8'h42) ^ 11'h200, 11); exp_err(1, "R7 parity");
        snap(); send_bits(mk(8'h42) | 11'h001, 11); exp_err(1, "R7 start");
        snap(); send_bits(mk(8'h42) & 11'h3FF, 11); exp_err(1, "R7 stop");
        snap(); send_bits(mk(8'h42), 11); exp_evt(8'h42, 1'b0, 1'b0, "R7 recovery");

        // R8: error clears pending prefix
        snap(); send_bits(mk(8'hF0), 11); send_bits(mk(8'h3A) ^ 11'h200, 11);
        exp_err(1, "R8 err mid seq");
        snap(); send_bits(mk(8'h3A), 11); exp_evt(8'h3A, 1'b0, 1'b0, "R8 prefix cleared");
        snap(); send_bits(mk(8'hE0), 11); send_bits(mk(8'h3A) | 11'h001, 11);
        exp_err(1, "R8 err after E0");
        snap(); send_bits(mk(8'h3B), 11); exp_evt(8'h3B, 1'b0, 1'b0, "R8 ext cleared");

        // R9: stalled partial frame is dropped without error
        snap(); send_bits(mk(8'h5A), 5); repeat (TMO + 50) @(negedge clk);
        exp_err(0, "R9 stall");
        snap(); send_bits(mk(8'h5A), 11); exp_evt(8'h5A, 1'b0, 1'b0, "R9 after stall");

        // R10: short clock glitches while idle are ignored
        snap();
        @(negedge clk); kb_clk = 1'b0; repeat (FILT - 2) @(negedge clk); kb_clk = 1'b1;
        repeat (GAP) @(negedge clk);
        send_bits(mk(8'h66), 11);
        exp_evt(8'h66, 1'b0, 1'b0, "R10 glitch");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule